// File: doc/BRIEF.md
# Parallel ATA Strobe Timing Generator

This block drives the host-side read and write strobes of one parallel ATA channel. It covers programmed-I/O and multiword-DMA data cycles and accesses to the task-file registers. A 32-bit timing word, normally one per attached device, holds separate clock counts for data cycles and for register accesses. Each transfer runs through three phases: a first-cycle setup phase with both strobes high, an active phase with exactly one strobe low, and a recovery phase with both strobes high again. All lengths are counted in controller clocks.

Requests enter on a valid/ready handshake. A request carries a direction flag, a register-access flag, a multiword-DMA flag and the write data. Back-pressure rules: `req_ready` is high only while the channel is idle or in the final recovery clock. The requester holds `req_valid` and every request field stable until a clock edge on which both `req_valid` and `req_ready` are high. A request accepted in the final recovery clock continues the burst and skips the setup phase. Read data is captured from the device bus on the edge that ends the active phase. A one-clock `done` pulse marks the end of each transfer. Writing the channel control code 0x37 aborts whatever is in progress.

Top module: `pata_strobe_gen`

## Requirements
- R1: After reset the channel is idle: `dior_n` and `diow_n` are high, `done` is low, and `req_ready` is high for any request that is not a blocked DMA request.
- R2: A data-port request (`req_cmd`=0) has a setup phase of tim_word[24:22] clocks, an active phase of tim_word[8:4]+1 clocks and a recovery phase of tim_word[3:0]+1 clocks. A setup field of zero means no setup phase.
- R3: A register request (`req_cmd`=1) uses tim_word[27:25] clocks of setup, tim_word[17:13]+1 clocks active and tim_word[12:9]+1 clocks of recovery, and ignores the data fields.
- R4: During the active phase only `diow_n` (write, `req_write`=1) or only `dior_n` (read) is low. Neither strobe is low in setup, recovery or idle. `dd_oe` is high and `dd_out` carries the write data while `diow_n` is low.
- R5: `rd_data` takes the value of `dd_in` present in the last active clock of a read, and changes at no other time.
- R6: `done` is high for exactly one clock, the clock after the last recovery clock of each transfer.
- R7: A data request with `req_dma`=1 is accepted only when tim_word[29] is 1. While that bit is 0, `req_ready` stays low and no strobe moves. A register request ignores `req_dma`.
- R8: A request accepted in the final recovery clock starts its active phase in the next clock, with no setup phase, in the same clock as `done`.
- R9: The timing word is sampled only when a request is accepted from idle. Changes to `tim_word` during a transfer or a continued burst do not alter its phase lengths.
- R10: A clock with `ctl_wr`=1 and `ctl_code`=0x37 returns the channel to idle in the next clock, with both strobes high and no `done` pulse for the aborted transfer. Any other code has no effect.
- R11: `req_ready` is low in every clock in which a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Channel control write strobe |
| ctl_code | input | 8 | Channel control code; 0x37 aborts |
| tim_word | input | 32 | Packed timing word for the addressed device |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write (DIOW), 0 = read (DIOR) |
| req_cmd | input | 1 | 1 = task-file register access, 0 = data port |
| req_dma | input | 1 | 1 = multiword-DMA data cycle |
| req_wdata | input | 16 | Write data for the request |
| dd_in | input | 16 | Device data bus, input side |
| dd_out | output | 16 | Device data bus, output side |
| dd_oe | output | 1 | Output enable for dd_out |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| rd_data | output | 16 | Data captured at the end of a read strobe |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
The bench counts the clocks of each phase for data and register accesses at the minimum and maximum field values. A design that mixed up the data and register field pairs, or dropped the plus-one rule, would show the wrong phase lengths. Read data is driven with a new value in every active clock, so a capture one clock early or late returns the wrong word. The directed tests cover a burst in which the timing word changes mid-transfer, a DMA request held off by a clear enable bit, and an abort issued during a long active phase next to a harmless control code. A design that reloaded the word early, inserted setup between burst members, let a blocked DMA request through or ignored the abort would fail these checks.

// File: rtl/pata_strobe_pkg.sv
package pata_strobe_pkg;

  localparam int TIM_W      = 32;

  localparam int SETUP_W    = 3;
  localparam int ACT_W      = 5;
  localparam int REC_W      = 4;

  localparam int D_REC_LSB  = 0;
  localparam int D_ACT_LSB  = 4;
  localparam int C_REC_LSB  = 9;
  localparam int C_ACT_LSB  = 13;
  localparam int UDMA_LSB   = 18;
  localparam int UDMA_W     = 4;
  localparam int D_SET_LSB  = 22;
  localparam int C_SET_LSB  = 25;
  localparam int UDMA_EN    = 28;
  localparam int MWDMA_EN   = 29;
  localparam int MISC_MSB   = 31;
  localparam int MISC_W     = 2;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACTIVE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [ACT_W-1:0]   act;
    logic [REC_W-1:0]   rec;
  } cyc_len_t;

endpackage

// File: rtl/pata_tim_decode.sv
module pata_tim_decode
  import pata_strobe_pkg::*;
(
  input  logic [TIM_W-1:0] word,
  input  logic             cmd_sel,
  output cyc_len_t         len,
  output logic             dma_en
);

  logic unused_bits;
  assign unused_bits = ^{word[UDMA_LSB +: UDMA_W], word[UDMA_EN], word[MISC_MSB -: MISC_W]};

  always_comb begin
    if (cmd_sel) begin
      len.setup = word[C_SET_LSB +: SETUP_W];
      len.act   = word[C_ACT_LSB +: ACT_W];
      len.rec   = word[C_REC_LSB +: REC_W];
    end else begin
      len.setup = word[D_SET_LSB +: SETUP_W];
      len.act   = word[D_ACT_LSB +: ACT_W];
      len.rec   = word[D_REC_LSB +: REC_W];
    end
  end

  assign dma_en = word[MWDMA_EN];

endmodule

// File: rtl/pata_phase_ctr.sv
module pata_phase_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pata_rd_capture.sv
module pata_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dd_in,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= dd_in;
    end
  end

endmodule

// File: rtl/pata_strobe_gen.sv
module pata_strobe_gen
  import pata_strobe_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          CODE_W     = 8,
  parameter logic [7:0]  ABORT_CODE = 8'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CODE_W-1:0] ctl_code,
  input  logic [TIM_W-1:0]  tim_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_cmd,
  input  logic              req_dma,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dd_in,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  localparam int CNT_W = ACT_W;

  phase_e             ph_q, ph_d;
  logic [TIM_W-1:0]   tim_q;
  logic               wr_q, cmd_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               done_q, done_d;

  logic [TIM_W-1:0]   sel_word;
  cyc_len_t           len_new, len_cur;
  logic               dma_en_new, unused_dma_cur;

  logic               abort, ready_slot, dma_block, accept, from_idle;
  logic               ctr_load, ctr_zero, cap;
  logic [CNT_W-1:0]   ctr_val;

  assign abort    = ctl_wr && (ctl_code == CODE_W'(ABORT_CODE));
  assign sel_word = (ph_q == PH_IDLE) ? tim_word : tim_q;

  pata_tim_decode u_dec_new (
    .word    (sel_word),
    .cmd_sel (req_cmd),
    .len     (len_new),
    .dma_en  (dma_en_new)
  );

  pata_tim_decode u_dec_cur (
    .word    (tim_q),
    .cmd_sel (cmd_q),
    .len     (len_cur),
    .dma_en  (unused_dma_cur)
  );

  assign ready_slot = (ph_q == PH_IDLE) || ((ph_q == PH_RECOVER) && ctr_zero);
  assign dma_block  = req_dma && !req_cmd && !dma_en_new;
  assign req_ready  = ready_slot && !abort && !dma_block;
  assign accept     = req_valid && req_ready;
  assign from_idle  = accept && (ph_q == PH_IDLE);

  always_comb begin
    ph_d     = ph_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    cap      = 1'b0;
    done_d   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ctr_load = 1'b1;
          if (len_new.setup != '0) begin
            ph_d    = PH_SETUP;
            ctr_val = CNT_W'(len_new.setup - 1'b1);
          end else begin
            ph_d    = PH_ACTIVE;
            ctr_val = CNT_W'(len_new.act);
          end
        end
      end
      PH_SETUP: begin
        if (ctr_zero) begin
          ph_d     = PH_ACTIVE;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(len_cur.act);
        end
      end
      PH_ACTIVE: begin
        if (ctr_zero) begin
          ph_d     = PH_RECOVER;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(len_cur.rec);
          cap      = !wr_q;
        end
      end
      PH_RECOVER: begin
        if (ctr_zero) begin
          done_d = 1'b1;
          if (accept) begin
            ph_d     = PH_ACTIVE;
            ctr_load = 1'b1;
            ctr_val  = CNT_W'(len_new.act);
          end else begin
            ph_d = PH_IDLE;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (abort) begin
      ph_d     = PH_IDLE;
      ctr_load = 1'b0;
      cap      = 1'b0;
      done_d   = 1'b0;
    end
  end

  pata_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (abort),
    .load     (ctr_load),
    .load_val (ctr_val),
    .expired  (ctr_zero)
  );

  pata_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (cap),
    .dd_in   (dd_in),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      tim_q   <= '0;
      wr_q    <= 1'b0;
      cmd_q   <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
      if (from_idle) begin
        tim_q <= tim_word;
      end
      if (accept) begin
        wr_q    <= req_write;
        cmd_q   <= req_cmd;
        wdata_q <= req_wdata;
      end
    end
  end

  assign dior_n = !((ph_q == PH_ACTIVE) && !wr_q);
  assign diow_n = !((ph_q == PH_ACTIVE) && wr_q);
  assign dd_oe  = wr_q && (ph_q != PH_IDLE);
  assign dd_out = wdata_q;
  assign done   = done_q;

endmodule

// File: rtl/pata_strobe_gen_chk.sv
module pata_strobe_gen_chk #(
  parameter int         DATA_W     = 16,
  parameter int         CODE_W     = 8,
  parameter logic [7:0] ABORT_CODE = 8'h37
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic [CODE_W-1:0] ctl_code,
  input logic              req_ready,
  input logic              dd_oe,
  input logic              dior_n,
  input logic              diow_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              done
);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  assert_oe_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n |-> dd_oe);

  assert_capture_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(dior_n));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dior_n && diow_n));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_code == CODE_W'(ABORT_CODE)) |=> (dior_n && diow_n && !done));

  assert_no_ready_in_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> !req_ready);

endmodule

bind pata_strobe_gen pata_strobe_gen_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .ABORT_CODE(ABORT_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_code  (ctl_code),
  .req_ready (req_ready),
  .dd_oe     (dd_oe),
  .dior_n    (dior_n),
  .diow_n    (diow_n),
  .rd_data   (rd_data),
  .done      (done)
);

// File: tb/pata_strobe_gen_bench.sv
module pata_strobe_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_code = 8'h00;
  logic [31:0] tim_word = 32'h0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_cmd = 1'b0;
  logic        req_dma = 1'b0;
  logic [15:0] req_wdata = 16'h0;
  logic [15:0] dd_in = 16'h0;
  logic [15:0] dd_out;
  logic        dd_oe;
  logic        dior_n, diow_n;
  logic [15:0] rd_data;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pata_strobe_gen u_pata_strobe_gen (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_code(ctl_code),
    .tim_word(tim_word), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cmd(req_cmd), .req_dma(req_dma),
    .req_wdata(req_wdata), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
    .dior_n(dior_n), .diow_n(diow_n), .rd_data(rd_data), .done(done)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        wr;
    logic        cmd;
    logic        dma;
    logic [7:0]  s;
    logic [7:0]  a;
    logic [7:0]  r;
  } vec_t;

  // word layout: [3:0] data rec, [8:4] data act, [12:9] cmd rec, [17:13] cmd act,
  // [24:22] data setup, [27:25] cmd setup, [29] DMA enable
  localparam vec_t VECS [7] = '{
    '{32'h00800031, 1'b0, 1'b0, 1'b0, 8'd2, 8'd4,  8'd2},
    '{32'h00000000, 1'b1, 1'b0, 1'b0, 8'd0, 8'd1,  8'd1},
    '{32'h0AC0E411, 1'b0, 1'b1, 1'b0, 8'd5, 8'd8,  8'd3},
    '{32'h0E03FE00, 1'b1, 1'b1, 1'b0, 8'd7, 8'd32, 8'd16},
    '{32'h20400043, 1'b0, 1'b0, 1'b1, 8'd1, 8'd5,  8'd4},
    '{32'h01C021FF, 1'b1, 1'b0, 1'b0, 8'd7, 8'd32, 8'd16},
    '{32'h02004000, 1'b1, 1'b1, 1'b1, 8'd1, 8'd3,  8'd1}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // present a request at a falling edge, wait for acceptance, return at the
  // falling edge after the accepting rising edge with valid dropped
  task automatic send(input logic wr, input logic cmd, input logic dma, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cmd = cmd; req_dma = dma; req_wdata = wd;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // count phase lengths starting at the current falling edge; returns at the done sample
  task automatic measure(input string req, input int es, input int ea, input int er,
                         input logic wr, input logic [15:0] base, input logic [15:0] wd);
    int s = 0;
    int a = 0;
    int r = 0;
    int bad = 0;
    int rdy_bad = 0;
    while (dior_n && diow_n && !done && s < 300) begin
      s++;
      @(negedge clk);
    end
    while ((wr ? !diow_n : !dior_n) && a < 300) begin
      if (req_ready) rdy_bad++;
      if (wr) begin
        if (dd_out !== wd || !dd_oe || !dior_n) bad++;
      end else begin
        dd_in = base + 16'(a);
        if (!diow_n) bad++;
      end
      a++;
      @(negedge clk);
    end
    while (!done && r < 300) begin
      if (!dior_n || !diow_n) bad++;
      r++;
      @(negedge clk);
    end
    chk(req, "setup clocks", s, es);
    chk(req, "active clocks", a, ea);
    chk(req, "recovery clocks", r, er);
    chk("R4", "strobe/direction violations", bad, 0);
    chk("R11", "ready during strobe", rdy_bad, 0);
    if (!wr) chk("R5", "captured read data", rd_data, base + 16'(ea - 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk("R1", "dior_n after reset", dior_n, 1);
    chk("R1", "diow_n after reset", diow_n, 1);
    chk("R1", "done after reset", done, 0);
    chk("R1", "ready after reset", req_ready, 1);

    // table walk: R2 data fields, R3 command fields, R7 DMA accepted with bit 29
    for (int i = 0; i < 7; i++) begin
      string tag;
      tag = VECS[i].cmd ? "R3" : (VECS[i].dma ? "R7" : "R2");
      tim_word = VECS[i].word;
      send(VECS[i].wr, VECS[i].cmd, VECS[i].dma, 16'hA500 + 16'(i));
      measure(tag, int'(VECS[i].s), int'(VECS[i].a), int'(VECS[i].r), VECS[i].wr,
              16'h1000 * 16'(i + 1), 16'hA500 + 16'(i));
      chk("R6", "done at end of recovery", done, 1);
      @(negedge clk);
      chk("R6", "done one clock only", done, 0);
    end

    // R7: DMA data request blocked while bit 29 clear
    begin
      int held = 0;
      tim_word = 32'h00000000;
      req_valid = 1'b1; req_write = 1'b0; req_cmd = 1'b0; req_dma = 1'b1;
      repeat (10) begin
        @(negedge clk); #1;
        if (req_ready || !dior_n || !diow_n || done) held++;
      end
      chk("R7", "blocked DMA request activity", held, 0);
      req_valid = 1'b0;
      tim_word = 32'h20000000;
      send(1'b0, 1'b0, 1'b1, 16'h0);
      measure("R7", 0, 1, 1, 1'b0, 16'h7700, 16'h0);
      @(negedge clk);
    end

    // R8/R9: burst with the timing word changed mid-transfer
    tim_word = 32'h00C00052;
    send(1'b0, 1'b0, 1'b0, 16'h0);
    tim_word = 32'h00000000;
    req_valid = 1'b1; req_write = 1'b0; req_cmd = 1'b0; req_dma = 1'b0;
    measure("R9", 3, 6, 3, 1'b0, 16'h2200, 16'h0);
    chk("R6", "done for first burst member", done, 1);
    chk("R8", "next strobe with done (no setup)", dior_n, 0);
    req_valid = 1'b0;
    measure("R8", 0, 6, 3, 1'b0, 16'h3300, 16'h0);
    @(negedge clk);
    chk("R6", "done one clock after burst", done, 0);
    send(1'b0, 1'b0, 1'b0, 16'h0);
    measure("R9", 0, 1, 1, 1'b0, 16'h4400, 16'h0);
    @(negedge clk);

    // R10: abort during a long active phase
    begin
      int late = 0;
      tim_word = 32'h000001F0;
      send(1'b0, 1'b0, 1'b0, 16'h0);
      @(negedge clk);
      chk("R10", "strobe active before abort", dior_n, 0);
      ctl_wr = 1'b1; ctl_code = 8'h36;
      @(negedge clk);
      ctl_wr = 1'b0;
      chk("R10", "other control code ignored", dior_n, 0);
      ctl_wr = 1'b1; ctl_code = 8'h37;
      @(negedge clk);
      ctl_wr = 1'b0; #1;
      chk("R10", "dior_n after abort", dior_n, 1);
      chk("R10", "diow_n after abort", diow_n, 1);
      chk("R10", "ready after abort", req_ready, 1);
      repeat (40) begin
        if (done || !dior_n) late++;
        @(negedge clk);
      end
      chk("R10", "activity after abort", late, 0);
    end

    summary();
    $finish;
  end

endmodule